// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block is the hazard logic of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. It is purely combinational. Each cycle it looks at the register fields of the instruction in decode and at the register fields of the instructions in execute, memory and writeback. From those it computes four operand-source selects: two for the ALU inputs in execute and two for the equality comparator that resolves branches in decode. It also computes three pipeline strobes: the PC write enable, the fetch/decode register write enable, and a bubble insert into the decode/execute register.

Read-after-write hazards are resolved by bypassing wherever the value already exists somewhere in the pipeline. When two in-flight instructions write the same register, the one in the memory stage is chosen because it is the younger. The pipeline freezes only in two cases. The first is a load whose result is needed by the next instruction, since there is no load delay slot. The second is a branch in decode whose operand is still being computed in execute, or is still being loaded in memory. The ISA has one branch delay slot, so nothing is ever flushed. Register 0 is hard-wired to zero: it is never bypassed and never causes a freeze.

Top module: `hzc_top`

## Requirements
- R1: An ALU operand select reads 1 (memory-stage result) when the memory-stage instruction writes a nonzero register equal to that execute source field. Otherwise it falls back to the later rules, and 0 means the register file value.
- R2: An ALU operand select reads 2 (writeback-stage result) when only the writeback-stage instruction writes that nonzero source register.
- R3: When the memory-stage and writeback-stage instructions both write the register being read, the select names the memory stage (1). This holds for the ALU and for the branch comparator.
- R4: During a stall, pcWrite=0, ifIdWrite=0 and idExBubble=1. Without a stall the three outputs are 1, 1 and 0.
- R5: A stall is raised when the execute-stage instruction is a load writing a nonzero register that a used decode operand reads. A non-load producer in execute causes no stall for a non-branch consumer.
- R6: A branch in decode stalls when the execute-stage instruction writes a nonzero register that either comparator operand reads.
- R7: The branch comparator select reads 1 for a non-load memory-stage producer and 2 for a writeback-stage producer. A load in the memory stage that writes a comparator operand forces a stall, and that select reads 0.
- R8: A source field of register 0 always gives select 0, and a producer writing register 0 never stalls.
- R9: A decode operand marked unused never causes a load-use stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idSrcA | input | 5 | First source register of the decode instruction |
| idSrcB | input | 5 | Second source register of the decode instruction |
| idUsesA | input | 1 | Decode instruction reads idSrcA |
| idUsesB | input | 1 | Decode instruction reads idSrcB |
| idIsBranch | input | 1 | Decode instruction is a compare-and-branch |
| exSrcA | input | 5 | First source register of the execute instruction |
| exSrcB | input | 5 | Second source register of the execute instruction |
| exDst | input | 5 | Destination register of the execute instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memDst | input | 5 | Destination register of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| wbDst | input | 5 | Destination register of the writeback instruction |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| aluSelA | output | 2 | ALU operand A source: 0 register file, 1 memory, 2 writeback |
| aluSelB | output | 2 | ALU operand B source, same encoding |
| brSelA | output | 2 | Branch comparator operand A source, same encoding |
| brSelB | output | 2 | Branch comparator operand B source, same encoding |
| pcWrite | output | 1 | PC write enable |
| ifIdWrite | output | 1 | Fetch/decode register write enable |
| idExBubble | output | 1 | Load a NOP into the decode/execute register |

## Verification
A table of stage snapshots covers several cases. It holds quiet traffic with no matching fields, single matches in each stage, double matches in memory and writeback, and load and non-load producers feeding both ALU and branch consumers. Together these separate the source priority from the stall decision. Cases with register 0 and with an unused operand tell a correct filter apart from one that compares raw fields. Short cycle-by-cycle sequences follow. In one, two back-to-back writers of one register are followed by a reader, which shows that the select names the most recent writer. In another, a load is followed by its consumer, which shows a single freeze and then a bypass from writeback.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  // Operand source encoding shared by the bypass muxes
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_MEM     = 2'd1,
    SRC_WB      = 2'd2
  } opSrc_e;

  // Strobes from the interlock control to the pipeline registers
  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic idExBubble;
  } pipeStrobe_t;
endpackage

// File: rtl/hzc_bypass.sv
module hzc_bypass
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] exSrcA,
  input  logic [REG_AW-1:0] exSrcB,
  input  logic [REG_AW-1:0] idSrcA,
  input  logic [REG_AW-1:0] idSrcB,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memRegWrite,
  input  logic              memIsLoad,
  input  logic [REG_AW-1:0] wbDst,
  input  logic              wbRegWrite,
  output opSrc_e            aluSelA,
  output opSrc_e            aluSelB,
  output opSrc_e            brSelA,
  output opSrc_e            brSelB
);
  localparam int NUM_OPS = 4;   // two ALU operands, two comparator operands
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [REG_AW-1:0] opSrc [NUM_OPS];
  opSrc_e            opSel [NUM_OPS];

  assign opSrc[0] = exSrcA;
  assign opSrc[1] = exSrcB;
  assign opSrc[2] = idSrcA;
  assign opSrc[3] = idSrcB;

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : gOperand
      // Operands 2 and 3 sit in decode and feed the branch comparator
      localparam bit IN_DECODE = (g >= 2);
      logic memHit, wbHit;

      assign memHit = memRegWrite && (memDst != ZERO_REG) && (memDst == opSrc[g]);
      assign wbHit  = wbRegWrite  && (wbDst  != ZERO_REG) && (wbDst  == opSrc[g]);

      always_comb begin
        if (memHit) begin
          // load data is not yet back for a decode consumer: interlock instead
          opSel[g] = (IN_DECODE && memIsLoad) ? SRC_REGFILE : SRC_MEM;
        end else if (wbHit) begin
          opSel[g] = SRC_WB;
        end else begin
          opSel[g] = SRC_REGFILE;
        end
      end

      always_comb begin
        if (opSrc[g] == ZERO_REG) begin
          assert_zero_src_R8: assert (opSel[g] == SRC_REGFILE)
            else $error("register 0 bypassed on operand %0d", g);
        end
        if (memRegWrite && wbRegWrite && (memDst == wbDst) && (memDst == opSrc[g])
            && (opSrc[g] != ZERO_REG) && !(IN_DECODE && memIsLoad)) begin
          assert_young_wins_R3: assert (opSel[g] == SRC_MEM)
            else $error("older producer chosen on operand %0d", g);
        end
      end
    end
  endgenerate

  assign aluSelA = opSel[0];
  assign aluSelB = opSel[1];
  assign brSelA  = opSel[2];
  assign brSelB  = opSel[3];
endmodule

// File: rtl/hzc_interlock.sv
module hzc_interlock
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] idSrcA,
  input  logic [REG_AW-1:0] idSrcB,
  input  logic              idUsesA,
  input  logic              idUsesB,
  input  logic              idIsBranch,
  input  logic [REG_AW-1:0] exDst,
  input  logic              exRegWrite,
  input  logic              exIsLoad,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memRegWrite,
  input  logic              memIsLoad,
  output pipeStrobe_t       strobe
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic exReadsA, exReadsB, memReadsA, memReadsB;
  logic loadUseStall, branchExStall, branchLoadStall, stall;

  assign exReadsA  = exRegWrite  && (exDst  != ZERO_REG) && idUsesA && (exDst  == idSrcA);
  assign exReadsB  = exRegWrite  && (exDst  != ZERO_REG) && idUsesB && (exDst  == idSrcB);
  assign memReadsA = memRegWrite && (memDst != ZERO_REG) && idUsesA && (memDst == idSrcA);
  assign memReadsB = memRegWrite && (memDst != ZERO_REG) && idUsesB && (memDst == idSrcB);

  // load result exists only after the memory stage
  assign loadUseStall    = exIsLoad && (exReadsA || exReadsB);
  // comparator in decode cannot see a value still being computed in execute
  assign branchExStall   = idIsBranch && (exReadsA || exReadsB);
  assign branchLoadStall = idIsBranch && memIsLoad && (memReadsA || memReadsB);
  assign stall           = loadUseStall || branchExStall || branchLoadStall;

  always_comb begin
    strobe.pcWrite    = !stall;
    strobe.ifIdWrite  = !stall;
    strobe.idExBubble = stall;
  end
endmodule

// File: rtl/hzc_top.sv
module hzc_top
  import hzc_pkg::*;
(
  input  logic [4:0] idSrcA,
  input  logic [4:0] idSrcB,
  input  logic       idUsesA,
  input  logic       idUsesB,
  input  logic       idIsBranch,
  input  logic [4:0] exSrcA,
  input  logic [4:0] exSrcB,
  input  logic [4:0] exDst,
  input  logic       exRegWrite,
  input  logic       exIsLoad,
  input  logic [4:0] memDst,
  input  logic       memRegWrite,
  input  logic       memIsLoad,
  input  logic [4:0] wbDst,
  input  logic       wbRegWrite,
  output logic [1:0] aluSelA,
  output logic [1:0] aluSelB,
  output logic [1:0] brSelA,
  output logic [1:0] brSelB,
  output logic       pcWrite,
  output logic       ifIdWrite,
  output logic       idExBubble
);
  localparam int REG_AW = 5;

  opSrc_e      selAluA, selAluB, selBrA, selBrB;
  pipeStrobe_t strobe;

  hzc_bypass #(.REG_AW(REG_AW)) bypass_i (
    .exSrcA(exSrcA), .exSrcB(exSrcB), .idSrcA(idSrcA), .idSrcB(idSrcB),
    .memDst(memDst), .memRegWrite(memRegWrite), .memIsLoad(memIsLoad),
    .wbDst(wbDst), .wbRegWrite(wbRegWrite),
    .aluSelA(selAluA), .aluSelB(selAluB), .brSelA(selBrA), .brSelB(selBrB)
  );

  hzc_interlock #(.REG_AW(REG_AW)) interlock_i (
    .idSrcA(idSrcA), .idSrcB(idSrcB), .idUsesA(idUsesA), .idUsesB(idUsesB),
    .idIsBranch(idIsBranch),
    .exDst(exDst), .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
    .memDst(memDst), .memRegWrite(memRegWrite), .memIsLoad(memIsLoad),
    .strobe(strobe)
  );

  assign aluSelA    = selAluA;
  assign aluSelB    = selAluB;
  assign brSelA     = selBrA;
  assign brSelB     = selBrB;
  assign pcWrite    = strobe.pcWrite;
  assign ifIdWrite  = strobe.ifIdWrite;
  assign idExBubble = strobe.idExBubble;

  // Cross-module checks between bypass selects and interlock strobes
  always_comb begin
    assert_freeze_pair_R4: assert ((pcWrite == ifIdWrite) && (idExBubble == !pcWrite))
      else $error("strobes disagree");
    if (exIsLoad && exRegWrite && (exDst != 5'd0) && idUsesA && (exDst == idSrcA)) begin
      assert_load_use_R5: assert (idExBubble)
        else $error("load-use not interlocked");
    end
    if (idIsBranch && memIsLoad) begin
      assert_no_load_to_cmp_R7: assert ((selBrA != SRC_MEM) && (selBrB != SRC_MEM))
        else $error("load data bypassed into comparator");
    end
    if (idIsBranch && exRegWrite && (exDst != 5'd0) && idUsesB && (exDst == idSrcB)) begin
      assert_branch_ex_R6: assert (!pcWrite)
        else $error("branch reading execute result did not stall");
    end
  end
endmodule

// File: tb/hzc_top_tb_top.sv
module hzc_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [4:0] idSrcA, idSrcB, exSrcA, exSrcB, exDst, memDst, wbDst;
  logic idUsesA, idUsesB, idIsBranch, exRegWrite, exIsLoad;
  logic memRegWrite, memIsLoad, wbRegWrite;
  logic [1:0] aluSelA, aluSelB, brSelA, brSelB;
  logic pcWrite, ifIdWrite, idExBubble;

  int total = 0;
  int bad = 0;

  hzc_top dut_i (.*);

  typedef struct packed {
    logic [7:0] req;
    logic [4:0] iA, iB; logic uA, uB, br;
    logic [4:0] eA, eB, eD; logic eW, eL;
    logic [4:0] mD; logic mW, mL;
    logic [4:0] wD; logic wW;
    logic [1:0] xAluA, xAluB, xBrA, xBrB; logic xStall;
  } vec_t;

  localparam int NV = 15;
  // req | id A,B,usesA,usesB,br | ex A,B,dst,w,ld | mem dst,w,ld | wb dst,w | expect aluA,aluB,brA,brB,stall
  localparam vec_t VECS [NV] = '{
    '{8'd1, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd3, 5'd4, 5'd5, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0}, // R1 quiet
    '{8'd1, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd6, 5'd4, 5'd5, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd1,2'd0,2'd0,2'd0,1'b0}, // R1 mem
    '{8'd2, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd3, 5'd7, 5'd5, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd2,2'd0,2'd0,1'b0}, // R2 wb
    '{8'd3, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd9, 5'd9, 5'd5, 1'b1,1'b0, 5'd9, 1'b1,1'b0, 5'd9, 1'b1, 2'd1,2'd1,2'd0,2'd0,1'b0}, // R3 both
    '{8'd2, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd9, 5'd3, 5'd5, 1'b1,1'b0, 5'd9, 1'b0,1'b0, 5'd9, 1'b1, 2'd2,2'd0,2'd0,2'd0,1'b0}, // R2 mem no write
    '{8'd5, 5'd3, 5'd2, 1'b1,1'b1,1'b0, 5'd1, 5'd4, 5'd3, 1'b1,1'b1, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b1}, // R5 load-use
    '{8'd5, 5'd3, 5'd2, 1'b1,1'b1,1'b0, 5'd1, 5'd4, 5'd3, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0}, // R5 alu producer
    '{8'd9, 5'd1, 5'd3, 1'b1,1'b0,1'b0, 5'd1, 5'd4, 5'd3, 1'b1,1'b1, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0}, // R9 unused B
    '{8'd6, 5'd4, 5'd8, 1'b1,1'b1,1'b1, 5'd1, 5'd2, 5'd8, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b1}, // R6 branch on ex
    '{8'd7, 5'd4, 5'd8, 1'b1,1'b1,1'b1, 5'd1, 5'd2, 5'd5, 1'b1,1'b0, 5'd4, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd1,2'd0,1'b0}, // R7 mem alu
    '{8'd7, 5'd4, 5'd8, 1'b1,1'b1,1'b1, 5'd1, 5'd2, 5'd5, 1'b1,1'b0, 5'd4, 1'b1,1'b1, 5'd4, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b1}, // R7 mem load
    '{8'd7, 5'd4, 5'd10,1'b1,1'b1,1'b1, 5'd1, 5'd2, 5'd5, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd10,1'b1, 2'd0,2'd0,2'd0,2'd2,1'b0}, // R7 wb
    '{8'd3, 5'd11,5'd2, 1'b1,1'b1,1'b1, 5'd1, 5'd3, 5'd5, 1'b1,1'b0, 5'd11,1'b1,1'b0, 5'd11,1'b1, 2'd0,2'd0,2'd1,2'd0,1'b0}, // R3 comparator
    '{8'd8, 5'd0, 5'd0, 1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd0, 1'b1,1'b1, 5'd0, 1'b1,1'b0, 5'd0, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0}, // R8 zero reg
    '{8'd4, 5'd2, 5'd2, 1'b1,1'b1,1'b1, 5'd1, 5'd3, 5'd2, 1'b1,1'b1, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b1}  // R4 stall strobes
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    {idSrcA, idSrcB, exSrcA, exSrcB, exDst, memDst, wbDst} = '0;
    {idUsesA, idUsesB, idIsBranch, exRegWrite, exIsLoad} = '0;
    {memRegWrite, memIsLoad, wbRegWrite} = '0;
  endtask

  task automatic checkStrobes(input string tag, input logic stall);
    check(tag, {29'd0, pcWrite, ifIdWrite, idExBubble}, {29'd0, !stall, !stall, stall});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearIn();
    @(negedge clk); #1;
    // idle: nothing in flight, R4 no stall, R1 selects register file
    check("R1 idle aluA", {30'd0, aluSelA}, 32'd0);
    checkStrobes("R4 idle strobes", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {idSrcA, idSrcB, idUsesA, idUsesB, idIsBranch} =
        {VECS[i].iA, VECS[i].iB, VECS[i].uA, VECS[i].uB, VECS[i].br};
      {exSrcA, exSrcB, exDst, exRegWrite, exIsLoad} =
        {VECS[i].eA, VECS[i].eB, VECS[i].eD, VECS[i].eW, VECS[i].eL};
      {memDst, memRegWrite, memIsLoad} = {VECS[i].mD, VECS[i].mW, VECS[i].mL};
      {wbDst, wbRegWrite} = {VECS[i].wD, VECS[i].wW};
      #1;
      check($sformatf("R%0d vec%0d sels", VECS[i].req, i),
            {24'd0, aluSelA, aluSelB, brSelA, brSelB},
            {24'd0, VECS[i].xAluA, VECS[i].xAluB, VECS[i].xBrA, VECS[i].xBrB});
      checkStrobes($sformatf("R%0d vec%0d strobes", VECS[i].req, i), VECS[i].xStall);
    end

    // R3 sequence: I1 writes r2, I2 writes r2, I3 reads r2 (program order)
    @(negedge clk); clearIn();
    idSrcA = 5'd2; idUsesA = 1'b1; exDst = 5'd2; exRegWrite = 1'b1; memDst = 5'd2; memRegWrite = 1'b1; #1;
    checkStrobes("R3 seq I3 in decode", 1'b0);
    @(negedge clk); clearIn();
    exSrcA = 5'd2; memDst = 5'd2; memRegWrite = 1'b1; wbDst = 5'd2; wbRegWrite = 1'b1; #1;
    check("R3 seq I3 reads newest writer", {30'd0, aluSelA}, 32'd1);
    @(negedge clk); clearIn();
    exSrcB = 5'd2; wbDst = 5'd2; wbRegWrite = 1'b1; #1;
    check("R2 seq I4 reads from writeback", {30'd0, aluSelB}, 32'd2);

    // R5 load-use: one frozen cycle, then bubble ahead, then bypass from writeback
    @(negedge clk); clearIn();
    idSrcB = 5'd1; idUsesB = 1'b1; exDst = 5'd1; exRegWrite = 1'b1; exIsLoad = 1'b1; #1;
    checkStrobes("R5 seq cycle0 freeze", 1'b1);
    @(negedge clk); clearIn();
    idSrcB = 5'd1; idUsesB = 1'b1; memDst = 5'd1; memRegWrite = 1'b1; memIsLoad = 1'b1; #1;
    checkStrobes("R5 seq cycle1 release", 1'b0);
    @(negedge clk); clearIn();
    exSrcB = 5'd1; wbDst = 5'd1; wbRegWrite = 1'b1; #1;
    check("R5 seq cycle2 wb bypass", {30'd0, aluSelB}, 32'd2);

    // R8 zero-register load with consumer: no freeze
    @(negedge clk); clearIn();
    idUsesA = 1'b1; exRegWrite = 1'b1; exIsLoad = 1'b1; #1;
    checkStrobes("R8 zero load no stall", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule